// File: doc/BRIEF.md
# Adaptive Hypothesis Selection Unit

This block sits at the leaf layer of a depth-first soft-output MIMO tree search. Each time a set of seven candidate symbols is ready, the block receives one metric and one bit label for each candidate. The set is a rounded reference symbol plus six neighbours along the real and imaginary axes. All candidate metrics are compared against one another at once. The resulting flag matrix picks out the candidate with the lowest metric, and that candidate becomes the candidate hypothesis, even when it is not the reference symbol. Every other candidate, the reference included, remains available as a counter-hypothesis.

The block holds one stored hypothesis (a metric and a label) and one counter-hypothesis metric per label bit. A stored value is replaced only when a new candidate offers a lower metric. A clear pulse at the start of each detection resets the stored state. A later stage reads the outputs and forms the log-likelihood values from them.

Top module: `adaptive_hyp_select`

## Requirements
- R1: While reset is active, and on the first cycle after it, every stored metric equals the all-ones maximum and the stored label is zero.
- R2: The candidate hypothesis is the candidate with the smallest metric. When several candidates share that metric, the one with the lowest index wins. Candidate i has its metric at cand_metric[i*MW +: MW] and its label at cand_label[i*LB +: LB].
- R3: On a valid strobe, the stored hypothesis metric and label are both replaced by those of the candidate hypothesis only if its metric is strictly lower than the stored metric. Otherwise both are kept.
- R4: On a valid strobe, for each bit k, the counter-hypothesis candidate is the lowest metric among the candidates whose label bit k differs from bit k of the hypothesis label in force after that strobe. This value replaces the stored entry at ctr_metric[k*MW +: MW] only if it is strictly lower. If no candidate qualifies, the entry is kept.
- R5: A clear pulse sets every stored metric to the maximum and the label to zero. Clear takes priority over a simultaneous valid strobe.
- R6: When neither clear nor the valid strobe is asserted, all outputs hold their values, whatever the candidate inputs carry.
- R7: The outputs reflect a strobe at the first clock edge that samples it. Before that edge they show the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Start-of-detection clear |
| cand_vld | input | 1 | Candidate set valid strobe |
| cand_metric | input | (LB+1)*MW | Packed candidate metrics |
| cand_label | input | (LB+1)*LB | Packed candidate bit labels |
| hyp_metric | output | MW | Stored hypothesis metric |
| hyp_label | output | LB | Stored hypothesis label |
| ctr_metric | output | LB*MW | Stored counter-hypothesis metric per bit |

## Verification
The bench places the minimum on a neighbour rather than on the reference, to check that the hypothesis is corrected. It also builds exact ties between candidates with different labels. A design that broke ties the wrong way would take the higher-index label, and one that used the same comparison in both directions would find no winner, or two winners OR-ed together. Candidate sets that are all worse than the stored hypothesis, or equal to the maximum, expose a design that replaces on equality or replaces unconditionally. Long pseudo-random sequences compare every per-bit entry against a model that uses the post-update label. A design that used the old label, or the winner itself, as the counter reference would diverge there. Clear raised together with a strobe, and idle cycles carrying garbage inputs, catch designs that get the priority wrong or update without the strobe.

// File: rtl/adaptive_hyp_select.sv
module adaptive_hyp_select #(
  parameter int LB = 6,
  parameter int MW = 8,
  localparam int NC = LB + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cand_vld,
  input  logic [NC*MW-1:0]   cand_metric,
  input  logic [NC*LB-1:0]   cand_label,
  output logic [MW-1:0]      hyp_metric,
  output logic [LB-1:0]      hyp_label,
  output logic [LB*MW-1:0]   ctr_metric
);

  localparam logic [MW-1:0] MMAX = '1;

  logic [MW-1:0] cm [NC];
  logic [LB-1:0] cl [NC];
  logic [NC-1:0] flg [NC];
  logic [NC-1:0] win;

  for (genvar i = 0; i < NC; i++) begin : g_unpack
    assign cm[i] = cand_metric[i*MW +: MW];
    assign cl[i] = cand_label[i*LB +: LB];
  end

  for (genvar p = 0; p < NC; p++) begin : g_row
    for (genvar q = 0; q < NC; q++) begin : g_col
      if (p == q) begin : g_d
        assign flg[p][q] = 1'b1;
      end else if (p < q) begin : g_le
        assign flg[p][q] = cm[p] <= cm[q];
      end else begin : g_lt
        assign flg[p][q] = cm[p] < cm[q];
      end
    end
    assign win[p] = &flg[p];
  end

  logic [MW-1:0] win_m;
  logic [LB-1:0] win_l;
  logic          take;
  logic [LB-1:0] nxt_l;
  logic [MW-1:0] best [LB];

  always_comb begin
    win_m = '0;
    win_l = '0;
    for (int i = 0; i < NC; i++) begin
      win_m |= {MW{win[i]}} & cm[i];
      win_l |= {LB{win[i]}} & cl[i];
    end
    take  = win_m < hyp_metric;
    nxt_l = take ? win_l : hyp_label;
    for (int k = 0; k < LB; k++) begin
      best[k] = MMAX;
      for (int i = 0; i < NC; i++)
        if (cl[i][k] != nxt_l[k] && cm[i] < best[k]) best[k] = cm[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hyp_metric <= MMAX;
      hyp_label  <= '0;
      ctr_metric <= {LB{MMAX}};
    end else if (cand_vld) begin
      if (take) begin
        hyp_metric <= win_m;
        hyp_label  <= win_l;
      end
      for (int k = 0; k < LB; k++)
        if (best[k] < ctr_metric[k*MW +: MW]) ctr_metric[k*MW +: MW] <= best[k];
    end
  end

  a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld |-> $onehot(win));

  a_r3_hyp_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> hyp_metric <= $past(hyp_metric));

  a_r4_ctr_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ctr_metric[MW-1:0] <= $past(ctr_metric[MW-1:0]));

  a_r5_clear_max: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hyp_metric == MMAX) && (hyp_label == '0) && (ctr_metric == {LB{MMAX}}));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cand_vld) |=> $stable(hyp_metric) && $stable(hyp_label) && $stable(ctr_metric));

endmodule

// File: tb/test_adaptive_hyp_select.sv
module test_adaptive_hyp_select;
  localparam int LB = 6;
  localparam int MW = 8;
  localparam int NC = LB + 1;

  logic clk = 0, rst_n = 0, clr = 0, cand_vld = 0;
  logic [NC*MW-1:0] cand_metric = '0;
  logic [NC*LB-1:0] cand_label = '0;
  logic [MW-1:0] hyp_metric;
  logic [LB-1:0] hyp_label;
  logic [LB*MW-1:0] ctr_metric;

  int checks = 0, failures = 0;
  logic [MW-1:0] m_in [NC];
  logic [LB-1:0] l_in [NC];
  logic [MW-1:0] e_hm;
  logic [LB-1:0] e_hl;
  logic [MW-1:0] e_cm [LB];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  adaptive_hyp_select #(.LB(LB), .MW(MW)) i_adaptive_hyp_select (
    .clk, .rst_n, .clr, .cand_vld, .cand_metric, .cand_label,
    .hyp_metric, .hyp_label, .ctr_metric);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, hyp_metric, e_hm);
    chk(req, hyp_label, e_hl);
    for (int k = 0; k < LB; k++) chk(req, ctr_metric[k*MW +: MW], e_cm[k]);
  endtask

  task automatic model_clear();
    e_hm = '1; e_hl = '0;
    for (int k = 0; k < LB; k++) e_cm[k] = '1;
  endtask

  task automatic pack();
    for (int i = 0; i < NC; i++) begin
      cand_metric[i*MW +: MW] = m_in[i];
      cand_label[i*LB +: LB]  = l_in[i];
    end
  endtask

  task automatic model_update();
    int w = 0;
    logic [MW-1:0] b;
    for (int i = 1; i < NC; i++) if (m_in[i] < m_in[w]) w = i;
    if (m_in[w] < e_hm) begin e_hm = m_in[w]; e_hl = l_in[w]; end
    for (int k = 0; k < LB; k++) begin
      b = '1;
      for (int i = 0; i < NC; i++)
        if (l_in[i][k] != e_hl[k] && m_in[i] < b) b = m_in[i];
      if (b < e_cm[k]) e_cm[k] = b;
    end
  endtask

  task automatic step(string req);
    pack();
    cand_vld = 1;
    #2;
    check_all({req, " R7 before edge"});
    @(negedge clk);
    cand_vld = 0;
    model_update();
    check_all(req);
  endtask

  task automatic t_reset();
    model_clear();
    check_all("R1 reset");
  endtask

  task automatic t_basic();
    for (int i = 0; i < NC; i++) begin m_in[i] = 8'd100 + 8'(i*7); l_in[i] = 6'(i*9 + 1); end
    m_in[3] = 8'd20;
    step("R2 R3 R4 neighbour min");
  endtask

  task automatic t_tie();
    model_clear(); clr = 1; @(negedge clk); clr = 0;
    for (int i = 0; i < NC; i++) begin m_in[i] = 8'd90; l_in[i] = 6'(i); end
    m_in[2] = 8'd15; l_in[2] = 6'h2A;
    m_in[5] = 8'd15; l_in[5] = 6'h15;
    step("R2 tie lowest index");
  endtask

  task automatic t_worse();
    for (int i = 0; i < NC; i++) begin m_in[i] = 8'd200 + 8'(i); l_in[i] = 6'(~i); end
    m_in[0] = e_hm;
    step("R3 no better candidate");
    for (int i = 0; i < NC; i++) begin m_in[i] = 8'hFF; l_in[i] = 6'h3F; end
    step("R3 R4 max metrics");
  endtask

  task automatic t_idle();
    for (int i = 0; i < NC; i++) begin m_in[i] = 8'd0; l_in[i] = 6'(i + 3); end
    pack();
    repeat (3) @(negedge clk);
    check_all("R6 idle hold");
  endtask

  task automatic t_clear();
    clr = 1; cand_vld = 1;
    @(negedge clk);
    clr = 0; cand_vld = 0;
    model_clear();
    check_all("R5 clear over strobe");
  endtask

  task automatic t_random(int n);
    for (int r = 0; r < n; r++) begin
      if (r % 16 == 0) begin clr = 1; @(negedge clk); clr = 0; model_clear(); end
      for (int i = 0; i < NC; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_in[i] = lfsr[7:0] | 8'd32;
        if (lfsr[9:8] == 2'b00 && i > 0) m_in[i] = m_in[i-1];
        l_in[i] = lfsr[15:10];
      end
      step("R4 random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_worse();
    t_idle();
    t_clear();
    t_random(400);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule